// File: doc/BRIEF.md
# Bounded Memory Access Protection Unit

This unit sits on the address path between the processor and main storage and checks every memory reference before storage sees it. Two protected windows are enforced. The first is a reserved window fixed by parameters. The second is a movable window whose lower and upper limits are held in two internal limit registers. Those registers mirror two dedicated words that lie inside the reserved window. A reference that lands in either window is stopped: the forwarded storage strobe stays low, no read response comes back, and a protection interrupt is raised.

The limit registers are loaded through a separate port whenever control passes to another user program. That port writes a storage-word address and a value. A load is accepted only while the interrupt system reports itself disabled. The interrupt output is a sticky flag. It holds the first offending address until an acknowledge clears it.

Top module: `mpu_guard`

## Requirements
- R1: A valid request outside both protected windows is forwarded in the same cycle: mem_valid=1 and mem_addr, mem_write and mem_wdata equal the request's fields.
- R2: A request whose address lies in FIX_LO..FIX_HI (inclusive; default 0x0000..0x00FF) gives mem_valid=0 in that cycle. This includes the two limit words.
- R3: A request whose address lies in lower..upper, both limits inclusive, gives mem_valid=0 in that cycle.
- R4: If the lower limit is greater than the upper limit, the movable window is empty. After reset, lower is all ones and upper is zero, so the window starts empty.
- R5: With irq_enabled=0, a load with bnd_wr_addr equal to LO_SLOT (default 0x0010) sets the lower limit, and one equal to HI_SLOT (default 0x0011) sets the upper limit. A load to any other address changes nothing. A load takes effect from the next cycle.
- R6: A load presented while irq_enabled=1 is ignored, and both limits keep their values.
- R7: One cycle after a forwarded read, rsp_valid=1 and rsp_rdata equals mem_rdata. After a blocked read, or after a write, rsp_valid=0 and rsp_rdata=0.
- R8: A blocked request with no interrupt pending sets viol_irq on the next edge and captures its address in viol_addr. The flag stays set until an acknowledge arrives.
- R9: While the flag is pending, further blocked requests leave viol_addr unchanged. An acknowledge clears the flag on the next edge. If a blocked request arrives in the same cycle as the acknowledge, the flag stays set and captures the new address.
- R10: After reset, viol_irq=0, viol_addr=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_addr | input | AW | Request word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DW | Read response data, zero when not valid |
| mem_valid | output | 1 | Gated request strobe to storage |
| mem_addr | output | AW | Address to storage |
| mem_write | output | 1 | Write flag to storage |
| mem_wdata | output | DW | Write data to storage |
| mem_rdata | input | DW | Read data from storage, one cycle after the request |
| bnd_wr_en | input | 1 | Limit-word load strobe |
| bnd_wr_addr | input | AW | Limit-word address |
| bnd_wr_data | input | AW | Limit value |
| irq_enabled | input | 1 | Interrupt system enabled; loads are refused while high |
| viol_irq | output | 1 | Sticky protection interrupt |
| viol_addr | output | AW | Captured offending address |
| viol_ack | input | 1 | Clears the interrupt |

## Verification
The hardest case to reach from the ports is a blocked request that arrives in the same cycle as an acknowledge while an earlier interrupt is still pending. The test first holds a pending flag. It then sends a second violation without an acknowledge to show the captured address stays frozen. Finally it sends a third violation together with the acknowledge and expects the flag to stay set with the new address. Refused limit loads are shown at the ports by accessing the would-be window edge afterwards and seeing the access forwarded.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;
  // which limit register a load targets
  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_LOWER = 2'd1,
    SLOT_UPPER = 2'd2
  } limit_slot_e;

  localparam int unsigned N_WINDOWS = 2;
endpackage

// File: rtl/mpu_span_match.sv
module mpu_span_match #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  // inclusive window; an inverted pair means an empty window
  always_comb begin
    hit = (lo <= hi) && (addr >= lo) && (addr <= hi);
  end
endmodule

// File: rtl/mpu_limit_bank.sv
module mpu_limit_bank
  import mpu_guard_pkg::*;
#(
  parameter int unsigned       AW      = 16,
  parameter logic [AW-1:0]     LO_SLOT = 16'h0010,
  parameter logic [AW-1:0]     HI_SLOT = 16'h0011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_data,
  input  logic          irq_enabled,
  output logic [AW-1:0] lower_q,
  output logic [AW-1:0] upper_q
);
  limit_slot_e slot;

  always_comb begin
    slot = SLOT_NONE;
    if (wr_en && !irq_enabled) begin
      if (wr_addr == LO_SLOT)      slot = SLOT_LOWER;
      else if (wr_addr == HI_SLOT) slot = SLOT_UPPER;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lower_q <= '1;
      upper_q <= '0;
    end else begin
      case (slot)
        SLOT_LOWER: lower_q <= wr_data;
        SLOT_UPPER: upper_q <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mpu_viol_latch.sv
module mpu_viol_latch #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          viol,
  input  logic [AW-1:0] addr,
  input  logic          ack,
  output logic          irq_q,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      addr_q <= '0;
    end else if (viol && (!irq_q || ack)) begin
      irq_q  <= 1'b1;
      addr_q <= addr;
    end else if (ack) begin
      irq_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_guard_pkg::*;
#(
  parameter int unsigned   AW      = 16,
  parameter int unsigned   DW      = 32,
  parameter logic [AW-1:0] FIX_LO  = 16'h0000,
  parameter logic [AW-1:0] FIX_HI  = 16'h00FF,
  parameter logic [AW-1:0] LO_SLOT = 16'h0010,
  parameter logic [AW-1:0] HI_SLOT = 16'h0011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_write,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          bnd_wr_en,
  input  logic [AW-1:0] bnd_wr_addr,
  input  logic [AW-1:0] bnd_wr_data,
  input  logic          irq_enabled,
  output logic          viol_irq,
  output logic [AW-1:0] viol_addr,
  input  logic          viol_ack
);
  logic [AW-1:0] lower_q, upper_q;
  logic [AW-1:0] win_lo [N_WINDOWS];
  logic [AW-1:0] win_hi [N_WINDOWS];
  logic [N_WINDOWS-1:0] win_hit;
  logic blocked, viol;
  logic rd_ok_q;

  mpu_limit_bank #(.AW(AW), .LO_SLOT(LO_SLOT), .HI_SLOT(HI_SLOT)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bnd_wr_en), .wr_addr(bnd_wr_addr),
    .wr_data(bnd_wr_data), .irq_enabled(irq_enabled),
    .lower_q(lower_q), .upper_q(upper_q)
  );

  always_comb begin
    win_lo[0] = FIX_LO;
    win_hi[0] = FIX_HI;
    win_lo[1] = lower_q;
    win_hi[1] = upper_q;
  end

  for (genvar w = 0; w < N_WINDOWS; w++) begin : g_win
    mpu_span_match #(.AW(AW)) u_match (
      .addr(req_addr), .lo(win_lo[w]), .hi(win_hi[w]), .hit(win_hit[w])
    );
  end

  assign blocked   = |win_hit;
  assign viol      = req_valid && blocked;
  assign mem_valid = req_valid && !blocked;
  assign mem_addr  = req_addr;
  assign mem_write = req_write;
  assign mem_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (rst) rd_ok_q <= 1'b0;
    else     rd_ok_q <= mem_valid && !req_write;
  end

  assign rsp_valid = rd_ok_q;
  assign rsp_rdata = rd_ok_q ? mem_rdata : '0;

  mpu_viol_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .viol(viol), .addr(req_addr), .ack(viol_ack),
    .irq_q(viol_irq), .addr_q(viol_addr)
  );
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
  parameter int unsigned   AW     = 16,
  parameter int unsigned   DW     = 32,
  parameter logic [AW-1:0] FIX_LO = 16'h0000,
  parameter logic [AW-1:0] FIX_HI = 16'h00FF
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_write,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic          viol_irq,
  input logic [AW-1:0] viol_addr,
  input logic          viol_ack
);
  assert_fwd_addr_R1: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (req_valid && mem_addr == req_addr));

  assert_fixed_block_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= FIX_LO && req_addr <= FIX_HI) |-> !mem_valid);

  assert_rsp_origin_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(mem_valid && !req_write));

  assert_rsp_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_rdata == '0));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mem_valid && !viol_irq) |=> (viol_irq && viol_addr == $past(req_addr)));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (viol_irq && !viol_ack) |=> (viol_irq && $stable(viol_addr)));
endmodule

bind mpu_guard mpu_guard_chk #(.AW(AW), .DW(DW), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .viol_irq(viol_irq),
  .viol_addr(viol_addr), .viol_ack(viol_ack)
);

// File: tb/tb_mpu_guard.sv
`timescale 1ns/1ps
module tb_mpu_guard;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] FIX_LO = 16'h0000, FIX_HI = 16'h00FF;
  localparam logic [AW-1:0] LO_SLOT = 16'h0010, HI_SLOT = 16'h0011;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, mem_rdata = '0;
  logic bnd_wr_en = 0, irq_enabled = 1, viol_ack = 0;
  logic [AW-1:0] bnd_wr_addr = '0, bnd_wr_data = '0;
  logic rsp_valid, mem_valid, mem_write, viol_irq;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr, viol_addr;

  always #2 clk = ~clk;

  mpu_guard #(.AW(AW), .DW(DW), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI),
              .LO_SLOT(LO_SLOT), .HI_SLOT(HI_SLOT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .bnd_wr_en(bnd_wr_en), .bnd_wr_addr(bnd_wr_addr), .bnd_wr_data(bnd_wr_data),
    .irq_enabled(irq_enabled), .viol_irq(viol_irq), .viol_addr(viol_addr),
    .viol_ack(viol_ack)
  );

  typedef struct {
    logic          fwd;
    logic [AW-1:0] addr;
    logic          wr;
    logic          rv;
    logic [DW-1:0] rd;
    logic          irq;
    logic [AW-1:0] va;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // independent model state
  logic [AW-1:0] m_lo = '1, m_hi = '0, m_va = '0;
  logic m_irq = 0;

  function automatic bit in_win(logic [AW-1:0] a, logic [AW-1:0] lo, logic [AW-1:0] hi);
    return (lo <= hi) && (a >= lo) && (a <= hi);
  endfunction

  task automatic cyc(input bit v, input logic [AW-1:0] a, input bit wr, input bit ack,
                     input bit bw, input logic [AW-1:0] ba, input logic [AW-1:0] bd,
                     input bit ien, input string tag);
    exp_t e;
    bit blk;
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = wr; req_wdata = {~a, a};
    mem_rdata = {a, ~a}; viol_ack = ack;
    bnd_wr_en = bw; bnd_wr_addr = ba; bnd_wr_data = bd; irq_enabled = ien;
    blk = in_win(a, FIX_LO, FIX_HI) || in_win(a, m_lo, m_hi);
    e.fwd = v && !blk; e.addr = a; e.wr = wr;
    e.rv = e.fwd && !wr;
    e.rd = e.rv ? {a, ~a} : '0;
    if (v && blk && (!m_irq || ack)) begin m_irq = 1; m_va = a; end
    else if (ack) m_irq = 0;
    e.irq = m_irq; e.va = m_va; e.tag = tag;
    if (bw && !ien) begin
      if (ba == LO_SLOT) m_lo = bd;
      else if (ba == HI_SLOT) m_hi = bd;
    end
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: after each edge, compare against the scoreboard head
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(mem_valid == e.fwd, e.tag, "mem_valid", DW'(mem_valid), DW'(e.fwd));
        if (e.fwd) begin
          chk(mem_addr == e.addr && mem_write == e.wr && mem_wdata == {~e.addr, e.addr},
              e.tag, "mem_addr", DW'(mem_addr), DW'(e.addr));
        end
        chk(rsp_valid == e.rv, e.tag, "rsp_valid", DW'(rsp_valid), DW'(e.rv));
        chk(rsp_rdata == e.rd, e.tag, "rsp_rdata", rsp_rdata, e.rd);
        chk(viol_irq == e.irq, e.tag, "viol_irq", DW'(viol_irq), DW'(e.irq));
        chk(viol_addr == e.va, e.tag, "viol_addr", DW'(viol_addr), DW'(e.va));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc(0, 16'h0000, 0, 0, 0, 0, 0, 1, "R10");
    cyc(1, 16'h0400, 0, 0, 0, 0, 0, 1, "R1_R4_R7");
    cyc(1, 16'h0401, 1, 0, 0, 0, 0, 1, "R1_R7");
    cyc(1, 16'h0080, 0, 0, 0, 0, 0, 1, "R2_R8");
    cyc(0, 16'h0000, 0, 0, 0, 0, 0, 1, "R8");
    cyc(1, 16'h00FF, 1, 0, 0, 0, 0, 1, "R2_R9");
    cyc(0, 16'h0000, 0, 1, 0, 0, 0, 1, "R9");
    cyc(0, 16'h0000, 0, 0, 1, LO_SLOT, 16'h1000, 1, "R6");
    cyc(0, 16'h0000, 0, 0, 1, HI_SLOT, 16'h1FFF, 1, "R6");
    cyc(1, 16'h1000, 0, 0, 0, 0, 0, 1, "R6");
    cyc(0, 16'h0000, 0, 0, 1, LO_SLOT, 16'h1000, 0, "R5");
    cyc(0, 16'h0000, 0, 0, 1, HI_SLOT, 16'h1FFF, 0, "R5");
    cyc(0, 16'h0000, 0, 0, 1, 16'h0012, 16'h0000, 0, "R5");
    cyc(1, 16'h1000, 0, 0, 0, 0, 0, 1, "R3_R5");
    cyc(1, 16'h1800, 1, 0, 0, 0, 0, 1, "R3_R9");
    cyc(1, 16'h1FFF, 0, 1, 0, 0, 0, 1, "R3_R9");
    cyc(1, 16'h0FFF, 0, 1, 0, 0, 0, 1, "R3_R9");
    cyc(1, 16'h2000, 0, 0, 0, 0, 0, 1, "R3");
    cyc(0, 16'h0000, 0, 0, 1, LO_SLOT, 16'h3000, 0, "R4");
    cyc(0, 16'h0000, 0, 0, 1, HI_SLOT, 16'h2000, 0, "R4");
    cyc(1, 16'h2800, 0, 0, 0, 0, 0, 1, "R4");
    cyc(1, 16'h3000, 1, 0, 0, 0, 0, 1, "R4");
    cyc(1, LO_SLOT, 1, 0, 0, 0, 0, 1, "R2_R8");
    cyc(0, 16'h0000, 0, 0, 0, 0, 0, 1, "R8");
    @(negedge clk);
    req_valid = 0; bnd_wr_en = 0; viol_ack = 0;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule